// File: doc/BRIEF.md
# SPI Target Front End with Inter-Byte Timeout

This block is the peripheral side of a four-wire SPI link in mode 3: the clock idles high, input data is taken on the rising clock edge and output data changes on the falling edge. It runs on a system clock that is much faster than the serial clock. The serial clock, select and input data pins pass through two-flop synchronisers, and the block then finds edges in the system clock domain. Each byte is exchanged most significant bit first. When a full byte has arrived, the block shows it on `rx_data` with a one-cycle `rx_valid` strobe. `rx_first` marks whether that byte opened a new command.

The block does not decode commands. On the strobe of a command byte, a handler outside the block returns on `cmd_len` how many bytes follow. During those bytes the block sends out `tx_data`, which it captures at the first falling clock edge of each byte. During every command byte it sends a fixed idle code, 0x55, so the host can see that the target is ready for a new command.

A watchdog covers the gap between bytes. If bytes are still owed and none completes within `TIMEOUT_CYCLES` system clocks, the block drops the partial transaction and pulses `timeout`. It then treats the next byte as a command. The default timeout is 100 ms at 50 MHz.

Top module: `spi_target_frontend`

## Requirements
- R1: After the eighth rising edge of `sck` within one select-low period, `rx_data` holds the eight `mosi` bits sampled on those rising edges, first-sampled bit in bit 7. `rx_valid` is high for exactly one cycle: the third system clock edge after the eighth rising edge reaches the pin.
- R2: `miso` changes only after falling `sck` edges and presents the response byte bit 7 first, so a host sampling on each rising edge reads the whole byte.
- R3: While a command byte is being exchanged, `miso` carries 0x55 and that byte's strobe has `rx_first` high.
- R4: `cmd_len` is sampled in the strobe cycle of a command byte. That many following bytes have `rx_first` low. Each of them returns the `tx_data` value present at its first falling `sck` edge.
- R5: A command whose sampled `cmd_len` is 0 leaves the block waiting for a command, so the next byte has `rx_first` high and returns 0x55.
- R6: While bytes are owed, if no byte completes, `timeout` pulses for one cycle exactly `TIMEOUT_CYCLES`+1 cycles after the last strobe. After that the next byte has `rx_first` high and returns 0x55.
- R7: While no bytes are owed, `timeout` stays low however long the bus is quiet.
- R8: If `cs_n` rises before a byte's eighth rising `sck` edge, the partial bits are dropped and give no strobe. The next full byte is received intact, and the command state is unchanged.
- R9: `miso_en` follows the inverse of `cs_n` two system clock edges later. `miso` is 0 whenever `miso_en` is low.
- R10: While reset is held, and right after it, `rx_valid`, `timeout`, `miso` and `miso_en` are low, and the block is waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| sck | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low select from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_en | output | 1 | High while `miso` should be driven onto the bus |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_first | output | 1 | Qualifies `rx_valid`: byte was a command byte |
| cmd_len | input | LEN_W | Count of bytes after the command, sampled with a command strobe |
| tx_data | input | 8 | Response byte for the next non-command byte |
| timeout | output | 1 | One-cycle pulse when an unfinished transaction is dropped |

## Verification
The assertions rely on the host keeping each half period of `sck` at several system clocks. This spacing rules out back-to-back strobes. It also keeps `mosi` steady around each rising edge, so the two synchronised copies line up. The assertions also rely on `cmd_len` being settled during the command strobe cycle. The bench plays a host with six system clocks per half period. It opens select a few cycles before the first falling edge and closes it a few cycles after the last rising edge. It derives `cmd_len` combinationally from `rx_data`, as a handler would. Byte gaps stay well under the timeout, except in the one phase that tests the timeout.

// File: rtl/spi_target_frontend.sv
module spi_target_frontend #(
  parameter int          TIMEOUT_CYCLES = 5_000_000,
  parameter int          LEN_W          = 4,
  parameter logic [7:0]  IDLE_CODE      = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic             miso_en,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_first,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       tx_data,
  output logic             timeout
);

  localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYCLES - 1);

  logic [2:0]       sck_q, cs_q;
  logic [1:0]       mosi_q;
  logic [2:0]       bitcnt;
  logic             tx_loaded;
  logic [7:0]       tx_sh;
  logic [LEN_W-1:0] pending;
  logic [TW-1:0]    timer;

  wire sel      = ~cs_q[1];
  wire sck_rise = sel &  sck_q[1] & ~sck_q[2];
  wire sck_fall = sel & ~sck_q[1] &  sck_q[2];

  assign miso_en = sel;
  assign miso    = sel & tx_sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 3'b111;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      tx_loaded <= 1'b0;
      tx_sh     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_first  <= 1'b0;
      pending   <= '0;
      timer     <= '0;
      timeout   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      timeout  <= 1'b0;

      if (!sel) begin
        bitcnt    <= '0;
        tx_loaded <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_data <= {rx_data[6:0], mosi_q[1]};
          bitcnt  <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            rx_valid  <= 1'b1;
            rx_first  <= (pending == '0);
            tx_loaded <= 1'b0;
          end
        end
        if (sck_fall) begin
          if (!tx_loaded) begin
            tx_sh     <= (pending == '0) ? IDLE_CODE : tx_data;
            tx_loaded <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end

      if (rx_valid) begin
        timer   <= '0;
        pending <= rx_first ? cmd_len : pending - 1'b1;
      end else if (pending != '0) begin
        if (timer == TLAST) begin
          timer     <= '0;
          pending   <= '0;
          timeout   <= 1'b1;
          bitcnt    <= '0;
          tx_loaded <= 1'b0;
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_no_strobe_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rx_valid);

  assert_idle_on_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_loaded) && $past(pending) == '0 && !$past(timeout)) |-> tx_sh == IDLE_CODE);

  assert_timeout_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0 && !rx_valid) |=> !timeout);

  assert_miso_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_en |-> !miso);

endmodule

// File: tb/spi_target_frontend_test.sv
module spi_target_frontend_test;
  localparam int T = 300;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_en, rx_valid, rx_first, timeout;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic [3:0] cmd_len;

  always #10 clk = ~clk;

  assign cmd_len = {2'b00, rx_data[1:0]};

  spi_target_frontend #(.TIMEOUT_CYCLES(T), .LEN_W(4), .IDLE_CODE(8'h55)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_en(miso_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_first(rx_first), .cmd_len(cmd_len), .tx_data(tx_data), .timeout(timeout));

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int b_pending = 0;
  int to_cyc = -1;
  bit done = 0;
  logic cs_d1 = 1'b1, cs_d2 = 1'b1;
  int  q_cyc[$];
  logic [7:0] q_dat[$];
  logic q_first[$];

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    cs_d1 <= rst_n ? cs_n : 1'b1;
    cs_d2 <= rst_n ? cs_d1 : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit ev;
    bit et;
    ev = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
    chk(rx_valid == ev, "R1 strobe", rx_valid, ev);
    if (ev) begin
      chk(rx_data == q_dat[0], "R1 data", rx_data, q_dat[0]);
      chk(rx_first == q_first[0], "R4 first flag", rx_first, q_first[0]);
      void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_first.pop_front());
    end
    et = (to_cyc == cyc);
    chk(timeout == et, "R6/R7 timeout", timeout, et);
    if (et) begin b_pending = 0; to_cyc = -1; end
    chk(miso_en == !cs_d2, "R9 enable", miso_en, !cs_d2);
    if (!cs_d2 == 1'b0) chk(miso == 1'b0, "R9 quiet", miso, 0);
  end

  task automatic send_byte(input logic [7:0] mo, input logic [7:0] resp);
    logic [7:0] got;
    logic [7:0] exp_resp;
    bit first;
    first = (b_pending == 0);
    tx_data = resp;
    exp_resp = first ? 8'h55 : resp;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      mosi = mo[i];
      repeat (H) @(negedge clk);
      got[i] = miso;
      sck = 1'b1;
      if (i == 0) begin
        q_cyc.push_back(cyc + 3);
        q_dat.push_back(mo);
        q_first.push_back(first);
        if (first) b_pending = int'(mo[1:0]);
        else b_pending = b_pending - 1;
        to_cyc = (b_pending != 0) ? cyc + 3 + T + 1 : -1;
      end
      repeat (H) @(negedge clk);
    end
    chk(got == exp_resp, first ? "R3 idle code" : "R2/R4 response", got, exp_resp);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    chk(rx_valid == 0 && timeout == 0 && miso == 0 && miso_en == 0, "R10 reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rx_valid == 0 && timeout == 0 && miso_en == 0, "R10 after reset", timeout, 0);

    // R4 command with two following bytes
    send_byte(8'hA2, 8'h00);
    send_byte(8'h11, 8'h3C);
    send_byte(8'hFE, 8'hC3);
    // R5 zero-length command, then a one-byte command
    send_byte(8'h00, 8'hEE);
    send_byte(8'h81, 8'h77);
    send_byte(8'h5A, 8'h96);
    // R6 timeout after partial transaction
    send_byte(8'h03, 8'h00);
    send_byte(8'hC4, 8'hA5);
    repeat (T + 40) @(negedge clk);
    chk(b_pending == 0, "R6 dropped", b_pending, 0);
    send_byte(8'h40, 8'h99);
    // R8 partial byte aborted by select
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; mosi = i[0];
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
    send_byte(8'hB0, 8'h12);
    // R7 long idle with nothing owed
    cs_n = 1'b0;
    repeat (2 * T) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(q_cyc.size() == 0, "R1 all strobes seen", q_cyc.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule